// File: doc/BRIEF.md
# Prioritized CPU Interrupt Input Unit

This unit sits beside the control logic of a small 8-bit processor core and turns four interrupt pins into one prioritized request. One pin is non-maskable, one is latched on a rising edge, and two are sampled as levels. Before the unit looks at any pin, it passes that pin through a synchronizer. A serial-input pin is synchronized the same way, but only so that it can be reported.

Maskable requests are gated at two levels. The first level is one global enable flip-flop, which the core sets and clears with strobes. The second level is three per-input mask bits, which the core loads through a mask-write port. A mask write changes the mask bits only when its set-enable bit is 1. The core raises a boundary strobe at each instruction boundary. On a strobe, the unit accepts the highest-priority pending request, pulses `take` for one cycle, and presents the index and fixed vector address of that request. A status word gives the core the mask bits, the enable flag, the pending and pin states, and the serial input.

Top module: `irq_prio_unit`

## Requirements
- R1: A mask write with bit 3 of `mask_data` set loads bits 2..0 into the masks. Bit 0 masks the low level input (`lvl_lo_pin`), bit 1 masks the high level input (`lvl_hi_pin`) and bit 2 masks the edge input (`edge_pin`). A mask bit of 1 blocks its input.
- R2: A mask write with bit 3 clear leaves all three mask bits unchanged.
- R3: `ei_strobe` sets the global enable. `di_strobe` clears it, and so does the acceptance of any maskable request. While the enable is clear, no maskable request is taken.
- R4: A rising edge on `edge_pin` sets a pending flag. The flag stays set after the pin falls, and the input cannot request again until the pin goes low and then high.
- R5: `lvl_hi_pin` and `lvl_lo_pin` request only while they are high at the boundary strobe, and they leave no memory behind.
- R6: The edge pending flag is cleared by a mask write with bit 4 set, whatever the value of bit 3. It is also cleared when the edge input is accepted.
- R7: The non-maskable pin (`nmi_pin`) ignores the masks and the global enable. It must rise and stay high to be taken. After it is taken once, it is not taken again until it has gone low and then high.
- R8: The priority, from highest to lowest, is nmi, edge, high level, low level. `take_idx` is 3, 2, 1 and 0 for these inputs, and `take_vec` is 0x0024, 0x003C, 0x0034 and 0x002C.
- R9: The status word is laid out as follows. Bits 2..0 are the masks (edge, high level, low level) and bit 3 is the enable. Bit 4 is the synchronized low level pin, bit 5 the synchronized high level pin, bit 6 the edge pending flag and bit 7 the synchronized serial-input pin.
- R10: After reset, `status` is 0x07 (all inputs masked, enable clear, nothing pending) and `take` is 0.
- R11: A request is accepted only at a clock edge where `boundary` is high. `take` then goes high for exactly the following cycle, and `take_idx` and `take_vec` hold their values until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin |
| edge_pin | input | 1 | Rising-edge latched request pin |
| lvl_hi_pin | input | 1 | Level request pin, higher priority |
| lvl_lo_pin | input | 1 | Level request pin, lower priority |
| sin_pin | input | 1 | Serial-input pin, reported only |
| ei_strobe | input | 1 | Set global enable |
| di_strobe | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask-write strobe |
| mask_data | input | 8 | Mask-write word |
| boundary | input | 1 | Instruction-boundary sample strobe |
| status | output | 8 | Status word |
| take | output | 1 | One-cycle pulse: a request was accepted |
| take_idx | output | 2 | Index of the accepted input |
| take_vec | output | 16 | Vector address of the accepted input |

## Verification
A stuck edge-pending flag or enable flip-flop shows up in `status` on the cycle after the write or acceptance that should have changed it. It also shows up at the next boundary strobe, as a `take` that should not occur or as one that is missing. A lost re-arm on the non-maskable pin shows as a second `take` with index 3 while that pin is still held high. A wrong priority order shows in `take_idx` and `take_vec` one cycle after the strobe.

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_NMI     = 16'h0024,
  parameter logic [15:0] VEC_EDGE    = 16'h003C,
  parameter logic [15:0] VEC_HI      = 16'h0034,
  parameter logic [15:0] VEC_LO      = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_pin,
  input  logic        edge_pin,
  input  logic        lvl_hi_pin,
  input  logic        lvl_lo_pin,
  input  logic        sin_pin,
  input  logic        ei_strobe,
  input  logic        di_strobe,
  input  logic        mask_wr,
  input  logic [7:0]  mask_data,
  input  logic        boundary,
  output logic [7:0]  status,
  output logic        take,
  output logic [1:0]  take_idx,
  output logic [15:0] take_vec
);
  localparam int NPIN = 5;

  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] pins_s;
  logic lo_s, hi_s, edge_s, nmi_s, sin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= {sin_pin, nmi_pin, edge_pin, lvl_hi_pin, lvl_lo_pin};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign pins_s = stg[SYNC_STAGES-1];
  assign {sin_s, nmi_s, edge_s, hi_s, lo_s} = pins_s;

  logic edge_prev, nmi_prev, edge_pend, nmi_arm, ie;
  logic [2:0] mask;

  wire edge_rise = edge_s & ~edge_prev;
  wire nmi_rise  = nmi_s & ~nmi_prev;

  wire req_nmi  = nmi_arm & nmi_s;
  wire req_edge = ie & ~mask[2] & edge_pend;
  wire req_hi   = ie & ~mask[1] & hi_s;
  wire req_lo   = ie & ~mask[0] & lo_s;
  wire any_req  = req_nmi | req_edge | req_hi | req_lo;
  wire accept   = boundary & any_req;

  logic [1:0]  win_idx;
  logic [15:0] win_vec;
  always_comb begin
    if (req_nmi)       begin win_idx = 2'd3; win_vec = VEC_NMI;  end
    else if (req_edge) begin win_idx = 2'd2; win_vec = VEC_EDGE; end
    else if (req_hi)   begin win_idx = 2'd1; win_vec = VEC_HI;   end
    else               begin win_idx = 2'd0; win_vec = VEC_LO;   end
  end

  wire take_maskable = accept & ~req_nmi;
  wire take_edge     = accept & (win_idx == 2'd2);
  wire clr_edge      = take_edge | (mask_wr & mask_data[4]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_prev <= 1'b0;
      nmi_prev  <= 1'b0;
      edge_pend <= 1'b0;
      nmi_arm   <= 1'b0;
      ie        <= 1'b0;
      mask      <= 3'b111;
      take      <= 1'b0;
      take_idx  <= '0;
      take_vec  <= '0;
    end else begin
      edge_prev <= edge_s;
      nmi_prev  <= nmi_s;
      if (edge_rise)     edge_pend <= 1'b1;
      else if (clr_edge) edge_pend <= 1'b0;
      if (!nmi_s || (accept && req_nmi)) nmi_arm <= 1'b0;
      else if (nmi_rise)                 nmi_arm <= 1'b1;
      ie <= (ie | ei_strobe) & ~di_strobe & ~take_maskable;
      if (mask_wr && mask_data[3]) mask <= mask_data[2:0];
      take <= accept;
      if (accept) begin
        take_idx <= win_idx;
        take_vec <= win_vec;
      end
    end
  end

  assign status = {sin_s, edge_pend, hi_s, lo_s, ie, mask};
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ei_strobe,
  input logic        di_strobe,
  input logic        mask_wr,
  input logic [7:0]  mask_data,
  input logic        boundary,
  input logic [7:0]  status,
  input logic        take,
  input logic [1:0]  take_idx,
  input logic [15:0] take_vec
);
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr && mask_data[3] |=> status[2:0] == $past(mask_data[2:0])); // R1
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr && !mask_data[3] |=> status[2:0] == $past(status[2:0])); // R2
  AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    di_strobe |=> !status[3]); // R3
  AST_MASKABLE_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_idx != 2'd3 |-> !status[3]); // R3
  AST_EDGE_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_idx == 2'd2 && !$past(mask_wr) |-> !status[6] || $rose(status[6])); // R6
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(boundary)); // R11
  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> $stable(take_idx) && $stable(take_vec)); // R11
  AST_VEC_OF_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> take_vec == (take_idx == 2'd3 ? 16'h0024 : take_idx == 2'd2 ? 16'h003C :
                          take_idx == 2'd1 ? 16'h0034 : 16'h002C)); // R8
endmodule

bind irq_prio_unit irq_prio_unit_chk chk_i (.*);

// File: tb/irq_prio_unit_tb_top.sv
module irq_prio_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 0, edge_pin = 0, lvl_hi_pin = 0, lvl_lo_pin = 0, sin_pin = 0;
  logic ei_strobe = 0, di_strobe = 0, mask_wr = 0, boundary = 0;
  logic [7:0]  mask_data = '0;
  logic [7:0]  status;
  logic        take;
  logic [1:0]  take_idx;
  logic [15:0] take_vec;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_unit dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [7:0] d);
    mask_wr = 1; mask_data = d; cyc(1); mask_wr = 0; mask_data = '0;
  endtask

  task automatic set_ie(input logic on);
    if (on) ei_strobe = 1; else di_strobe = 1;
    cyc(1); ei_strobe = 0; di_strobe = 0;
  endtask

  task automatic strobe(output logic t, output logic [1:0] i, output logic [15:0] v);
    boundary = 1; cyc(1); boundary = 0;
    t = take; i = take_idx; v = take_vec;
  endtask

  task automatic t_reset;
    chk("R10 status", {8'h0, status}, 16'h0007);
    chk("R10 take", {15'h0, take}, 16'h0);
  endtask

  task automatic t_mask;
    wr_mask(8'h0A);
    chk("R1 load", {13'h0, status[2:0]}, 16'h2);
    wr_mask(8'h05);
    chk("R2 hold", {13'h0, status[2:0]}, 16'h2);
    wr_mask(8'h08);
    chk("R1 clear", {13'h0, status[2:0]}, 16'h0);
  endtask

  task automatic t_ie;
    logic t; logic [1:0] i; logic [15:0] v;
    set_ie(1);
    chk("R3 ei", {15'h0, status[3]}, 16'h1);
    set_ie(0);
    chk("R3 di", {15'h0, status[3]}, 16'h0);
    lvl_lo_pin = 1; cyc(4);
    strobe(t, i, v);
    chk("R3 ie off blocks", {15'h0, t}, 16'h0);
    lvl_lo_pin = 0; cyc(4);
  endtask

  task automatic t_level;
    logic t; logic [1:0] i; logic [15:0] v;
    set_ie(1);
    lvl_lo_pin = 1; cyc(4);
    chk("R11 no take without strobe", {15'h0, take}, 16'h0);
    strobe(t, i, v);
    chk("R5 lo take", {15'h0, t}, 16'h1);
    chk("R8 lo idx", {14'h0, i}, 16'h0);
    chk("R8 lo vec", v, 16'h002C);
    chk("R3 accept clears ie", {15'h0, status[3]}, 16'h0);
    cyc(1);
    chk("R11 one-cycle take", {15'h0, take}, 16'h0);
    chk("R11 idx held", take_vec, 16'h002C);
    lvl_lo_pin = 0; cyc(4);
    set_ie(1);
    strobe(t, i, v);
    chk("R5 low level no memory", {15'h0, t}, 16'h0);
    lvl_lo_pin = 1; lvl_hi_pin = 1; cyc(4);
    strobe(t, i, v);
    chk("R8 hi over lo idx", {14'h0, i}, 16'h1);
    chk("R8 hi vec", v, 16'h0034);
    set_ie(1);
    wr_mask(8'h0A);
    strobe(t, i, v);
    chk("R1 hi masked, lo taken", {14'h0, i}, 16'h0);
    wr_mask(8'h08);
    lvl_lo_pin = 0; lvl_hi_pin = 0; cyc(4);
  endtask

  task automatic t_edge;
    logic t; logic [1:0] i; logic [15:0] v;
    edge_pin = 1; cyc(4); edge_pin = 0; cyc(4);
    chk("R4 pend after fall", {15'h0, status[6]}, 16'h1);
    strobe(t, i, v);
    chk("R3 edge blocked by ie", {15'h0, t}, 16'h0);
    set_ie(1);
    wr_mask(8'h0C);
    strobe(t, i, v);
    chk("R1 edge masked", {15'h0, t}, 16'h0);
    chk("R4 pend kept while masked", {15'h0, status[6]}, 16'h1);
    wr_mask(8'h08);
    lvl_hi_pin = 1; cyc(4);
    strobe(t, i, v);
    chk("R8 edge over hi", {14'h0, i}, 16'h2);
    chk("R8 edge vec", v, 16'h003C);
    chk("R6 accept clears pend", {15'h0, status[6]}, 16'h0);
    lvl_hi_pin = 0;
    edge_pin = 1; cyc(4);
    chk("R4 new edge", {15'h0, status[6]}, 16'h1);
    wr_mask(8'h10);
    chk("R6 bit4 clears pend", {15'h0, status[6]}, 16'h0);
    cyc(4);
    chk("R4 held high no re-latch", {15'h0, status[6]}, 16'h0);
    edge_pin = 0; cyc(4);
  endtask

  task automatic t_nmi;
    logic t; logic [1:0] i; logic [15:0] v;
    set_ie(0);
    wr_mask(8'h0F);
    nmi_pin = 1; cyc(4);
    strobe(t, i, v);
    chk("R7 nmi ignores mask/ie", {15'h0, t}, 16'h1);
    chk("R8 nmi idx", {14'h0, i}, 16'h3);
    chk("R8 nmi vec", v, 16'h0024);
    cyc(2);
    strobe(t, i, v);
    chk("R7 no retake while held", {15'h0, t}, 16'h0);
    nmi_pin = 0; cyc(4);
    wr_mask(8'h08);
    set_ie(1);
    edge_pin = 1; lvl_lo_pin = 1; nmi_pin = 1; cyc(4);
    strobe(t, i, v);
    chk("R8 nmi wins all", {14'h0, i}, 16'h3);
    chk("R7 nmi leaves ie", {15'h0, status[3]}, 16'h1);
    strobe(t, i, v);
    chk("R8 edge next", {14'h0, i}, 16'h2);
    nmi_pin = 0; edge_pin = 0; lvl_lo_pin = 0; cyc(4);
  endtask

  task automatic t_status;
    wr_mask(8'h0D);
    lvl_lo_pin = 1; sin_pin = 1; cyc(4);
    chk("R9 status word", {8'h0, status}, 16'h0095);
    lvl_lo_pin = 0; lvl_hi_pin = 1; sin_pin = 0; set_ie(1); cyc(4);
    chk("R9 status word 2", {8'h0, status}, 16'h002D);
    lvl_hi_pin = 0; cyc(4);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1; cyc(2);
    t_reset();
    t_mask();
    t_ie();
    t_level();
    t_edge();
    t_nmi();
    t_status();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule